// File: doc/BRIEF.md
# Reverse-Carry Address Generator

This block keeps a 16-bit address pointer, a step offset and a mode register, and advances the pointer by the offset whenever an update strobe arrives. The mode register chooses how the offset is added. Any nonzero mode value gives ordinary binary addition. A zero mode value gives reverse-carry addition, in which each carry moves from a bit toward the next lower bit rather than the next higher one.

The reverse-carry mode is meant for reading the output of a radix-2 FFT, which is stored in scrambled order. The buffer holds 2^k points and starts at an address whose k low bits are zero. The pointer is loaded with that base and the offset with 2^(k-1). Each update then moves the pointer to base plus the bit-reversed value of the next counter index, so the bins come out in natural order and no counter has to be reversed in software. After 2^k updates the pointer is back at the base. Each register has its own load port, and the current pointer drives the address output.

Top module: `rc_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears the pointer, offset and mode registers to zero. Right after reset `addr` reads 0, and an update leaves it at 0.
- R2: When `ptr_ld` is high at a rising edge, `addr` shows `ptr_in` after that edge.
- R3: When the mode register is nonzero, an update sets the pointer to pointer + offset modulo 2^16 (for example 0xFFFF + 2 gives 0x0001).
- R4: When the mode register is zero, an update adds the offset with carries running from bit i to bit i-1. A carry out of bit 0 is lost (for example 0xFFFF + 1 gives 0xFFFE, and 3584 + 512 gives 3328).
- R5: In reverse-carry mode, with the offset equal to 2^(k-1) and the pointer loaded with a base B that is a multiple of 2^k, update number n leaves `addr` = B + rev_k(n mod 2^k). Here rev_k reverses the k low bits, and the pointer never leaves B .. B+2^k-1. Bits at position k and above never change.
- R6: In the setup of R5, the pointer equals B again after exactly 2^k updates.
- R7: If `ptr_ld` and `step` are both high in the same cycle, the load wins.
- R8: A write to the offset or mode register in the same cycle as an update does not affect that update. The new value first applies to the next update.
- R9: With `step` and `ptr_ld` low, `addr` holds its value, even when the offset or mode registers are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ptr_ld | input | 1 | Load the pointer from `ptr_in` |
| ptr_in | input | 16 | New pointer value |
| ofs_ld | input | 1 | Load the offset from `ofs_in` |
| ofs_in | input | 16 | New offset value |
| mod_ld | input | 1 | Load the mode register from `mod_in` |
| mod_in | input | 16 | New mode value; zero selects reverse-carry |
| step | input | 1 | Post-update strobe: pointer += offset |
| addr | output | 16 | Current pointer value |

## Verification
All results have a latency of one edge, because `addr` comes straight from the pointer register. A load or update applied at a rising edge appears on `addr` after that same edge, and the registers add no further stage. The bench changes its inputs on the falling edge and checks `addr` on the next falling edge, half a period after the edge that should have updated it. It therefore never samples in the middle of an update. For the R8 cases, the bench writes the offset or mode register in the same cycle as a step and checks the result of that step against the old setting, then checks the following step against the new one.

// File: rtl/rc_addr_pkg.sv
package rc_addr_pkg;
   localparam int ADDR_W = 16;

   typedef enum logic {
      UPD_LINEAR   = 1'b0,
      UPD_REVCARRY = 1'b1
   } upd_mode_e;
endpackage

// File: rtl/rc_bit_rev.sv
module rc_bit_rev #(
   parameter int W = 16
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   for (genvar i = 0; i < W; i++) begin : g_swap
      assign dout[i] = din[W-1-i];
   end
endmodule

// File: rtl/rc_adder.sv
module rc_adder #(
   parameter int W    = 16,
   parameter int IMPL = 0   // 0: mirror-add-mirror, 1: downward ripple
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   if (IMPL == 0) begin : g_mirror
      logic [W-1:0] a_r, b_r, s_r;
      rc_bit_rev #(.W(W)) u_ra (.din(a),   .dout(a_r));
      rc_bit_rev #(.W(W)) u_rb (.din(b),   .dout(b_r));
      assign s_r = a_r + b_r;
      rc_bit_rev #(.W(W)) u_rs (.din(s_r), .dout(sum));
   end else begin : g_ripple
      always_comb begin
         logic c;
         c = 1'b0;
         sum = '0;
         for (int i = W - 1; i >= 0; i--) begin
            sum[i] = a[i] ^ b[i] ^ c;
            c      = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
         end
      end
   end

   // R4
   always_comb begin
      if (b == '0) begin
         rc_zero_chk: assert (sum == a);
      end
   end
endmodule

// File: rtl/rc_addr_gen.sv
module rc_addr_gen
   import rc_addr_pkg::*;
#(
   parameter int W       = ADDR_W,
   parameter int RC_IMPL = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ptr_ld,
   input  logic [W-1:0] ptr_in,
   input  logic         ofs_ld,
   input  logic [W-1:0] ofs_in,
   input  logic         mod_ld,
   input  logic [W-1:0] mod_in,
   input  logic         step,
   output logic [W-1:0] addr
);
   if (W < 2) begin : g_bad_width
      $error("rc_addr_gen: W must be at least 2");
   end
   if (RC_IMPL != 0 && RC_IMPL != 1) begin : g_bad_impl
      $error("rc_addr_gen: RC_IMPL must be 0 or 1");
   end

   logic [W-1:0] ptr_q, ofs_q, mod_q;
   logic [W-1:0] rc_sum, lin_sum, nxt_ptr;
   upd_mode_e    mode;

   assign mode = (mod_q == '0) ? UPD_REVCARRY : UPD_LINEAR;

   rc_adder #(.W(W), .IMPL(RC_IMPL)) u_rc (
      .a   (ptr_q),
      .b   (ofs_q),
      .sum (rc_sum)
   );

   assign lin_sum = ptr_q + ofs_q;
   assign nxt_ptr = (mode == UPD_REVCARRY) ? rc_sum : lin_sum;

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q <= '0;
         ofs_q <= '0;
         mod_q <= '0;
      end else begin
         if (ptr_ld)      ptr_q <= ptr_in;
         else if (step)   ptr_q <= nxt_ptr;
         if (ofs_ld)      ofs_q <= ofs_in;
         if (mod_ld)      mod_q <= mod_in;
      end
   end

   assign addr = ptr_q;

   // mask of bits strictly above the single set bit of the offset
   logic [W:0]   ofs_x2_m1;
   logic [W-1:0] hi_mask;
   assign ofs_x2_m1 = {ofs_q, 1'b0} - {{W{1'b0}}, 1'b1};
   assign hi_mask   = ~ofs_x2_m1[W-1:0];

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (ptr_q == '0 && ofs_q == '0 && mod_q == '0));

   // R2
   ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
      ptr_ld |=> addr == $past(ptr_in));

   // R3
   lin_step_chk: assert property (@(posedge clk) disable iff (rst)
      (step && !ptr_ld && mod_q != '0) |=> addr == $past(ptr_q) + $past(ofs_q));

   // R5
   rc_window_chk: assert property (@(posedge clk) disable iff (rst)
      (step && !ptr_ld && mod_q == '0 && $onehot(ofs_q))
         |=> (addr & $past(hi_mask)) == ($past(ptr_q) & $past(hi_mask)));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!step && !ptr_ld) |=> $stable(addr));
endmodule

// File: tb/rc_addr_gen_test.sv
module rc_addr_gen_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        ptr_ld, ofs_ld, mod_ld, step;
   logic [15:0] ptr_in, ofs_in, mod_in;
   logic [15:0] addr;

   int nvec  = 0;
   int nfail = 0;
   bit done  = 0;

   always #2 clk = ~clk;   // 250 MHz

   rc_addr_gen uut (
      .clk(clk), .rst(rst),
      .ptr_ld(ptr_ld), .ptr_in(ptr_in),
      .ofs_ld(ofs_ld), .ofs_in(ofs_in),
      .mod_ld(mod_ld), .mod_in(mod_in),
      .step(step), .addr(addr)
   );

   typedef struct packed {
      logic [15:0] p;
      logic [15:0] o;
      logic [15:0] m;
      logic [15:0] e;
   } vec_t;

   // one-step vectors: pointer, offset, mode, expected addr after one update
   localparam vec_t VECS [10] = '{
      '{16'd100,   16'd5,     16'd1, 16'd105},   // R3
      '{16'hFFFF,  16'h0002,  16'd7, 16'h0001},  // R3 wrap
      '{16'h1234,  16'h0000,  16'd1, 16'h1234},  // R3
      '{16'd3072,  16'd512,   16'd0, 16'd3584},  // R4
      '{16'd3584,  16'd512,   16'd0, 16'd3328},  // R4
      '{16'd3328,  16'd512,   16'd0, 16'd3840},  // R4
      '{16'd3840,  16'd512,   16'd0, 16'd3200},  // R4
      '{16'h8000,  16'h8000,  16'd0, 16'h4000},  // R4
      '{16'hFFFF,  16'h0001,  16'd0, 16'hFFFE},  // R4 carry lost
      '{16'h0003,  16'h0001,  16'd0, 16'h0002}   // R4 carry lost
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ptr_ld = 0; ofs_ld = 0; mod_ld = 0; step = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic load_all(input logic [15:0] p, input logic [15:0] o, input logic [15:0] m);
      ptr_ld = 1; ptr_in = p;
      ofs_ld = 1; ofs_in = o;
      mod_ld = 1; mod_in = m;
      tick();
   endtask

   task automatic do_step();
      step = 1;
      tick();
   endtask

   function automatic logic [15:0] rev_k(input int n, input int k);
      logic [15:0] r;
      r = '0;
      for (int j = 0; j < k; j++) r[j] = n[k-1-j];
      return r;
   endfunction

   task automatic run_seq(input int k, input logic [15:0] base);
      load_all(base, 16'(1 << (k - 1)), 16'd0);
      chk("R2 base load", addr, base);
      for (int n = 1; n <= (1 << k); n++) begin
         do_step();
         if (n < (1 << k))
            chk($sformatf("R5 k=%0d n=%0d", k, n), addr, base + rev_k(n, k));
      end
      chk($sformatf("R6 k=%0d return to base", k), addr, base);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      ptr_in = '0; ofs_in = '0; mod_in = '0;
      rst = 1;
      @(negedge clk);
      tick();
      tick();
      rst = 0;
      chk("R1 reset addr", addr, 16'h0000);
      do_step();
      chk("R1 step after reset", addr, 16'h0000);

      // table walk
      for (int v = 0; v < 10; v++) begin
         load_all(VECS[v].p, VECS[v].o, VECS[v].m);
         chk($sformatf("R2 load v%0d", v), addr, VECS[v].p);
         do_step();
         chk($sformatf("R3/R4 step v%0d", v), addr, VECS[v].e);
      end

      // bit-reversed sequences
      run_seq(3,  16'h1238);
      run_seq(8,  16'hAB00);
      run_seq(10, 16'd3072);

      // R7: load beats update
      load_all(16'h0100, 16'h0010, 16'd1);
      ptr_ld = 1; ptr_in = 16'h5555; step = 1;
      tick();
      chk("R7 load wins", addr, 16'h5555);

      // R8: mode written with step
      load_all(16'h0100, 16'h0100, 16'd1);
      mod_ld = 1; mod_in = 16'd0; step = 1;
      tick();
      chk("R8 old mode used", addr, 16'h0200);
      do_step();
      chk("R8 new mode next", addr, 16'h0300);

      // R8: offset written with step
      load_all(16'h0010, 16'h0001, 16'd1);
      ofs_ld = 1; ofs_in = 16'h0020; step = 1;
      tick();
      chk("R8 old offset used", addr, 16'h0011);
      do_step();
      chk("R8 new offset next", addr, 16'h0031);

      // R9: no update, other registers written
      ofs_ld = 1; ofs_in = 16'h0777; mod_ld = 1; mod_in = 16'd0;
      tick();
      chk("R9 hold on reg writes", addr, 16'h0031);
      tick();
      chk("R9 hold idle", addr, 16'h0031);

      // R1: reset in mid-run clears all three registers
      load_all(16'h4321, 16'h0005, 16'd3);
      rst = 1;
      tick();
      rst = 0;
      chk("R1 mid-run reset", addr, 16'h0000);
      do_step();
      chk("R1 offset cleared", addr, 16'h0000);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule